// File: doc/BRIEF.md
# ACPI Sleep Control and Reset Port

This block holds the fixed-function power-management control register, the command port that moves the platform in and out of ACPI mode, and a one-byte reset control port. All three sit on one register bus. A request carries a valid strobe, a read/write flag, an address, an access size and write data. The block returns read data and an error flag in the same cycle.

Firmware or the operating system enables ACPI mode by writing a command code to the command port. This sets the SCI enable flag and arms power-button forwarding. The OS writes the sleep-type field and the sleep-enable strobe into the control register. Entering sleep state 5 produces a single-cycle power-off request to the power sequencer. Setting the reset-trigger bit in the reset port produces a single-cycle request to the reset generator. The sequencer and the reset generator are outside this block.

Top module: `acpi_sleep_ctrl`

## Requirements
- R1: After synchronous reset, every readable register returns 0, and `sci_enable`, `pwrbtn_arm`, `pwroff_req` and `sysrst_req` are 0.
- R2: A valid 16-bit write to the control address stores data bits 12:2. Reading it back returns those bits, with bits 15:13 and bit 1 as 0 and bit 0 equal to the SCI enable flag. Bits 12:10 hold the sleep type and bit 13 is the sleep-enable strobe.
- R3: No write to the control register changes the SCI enable flag.
- R4: A control write with data bit 13 = 1 and data bits 12:10 = 5 makes `pwroff_req` high for exactly the cycle after the write. A control write with bit 13 = 1 and any other sleep type leaves `pwroff_req` low.
- R5: The control register accepts only 16-bit accesses (`req_size` = 1). The command and reset ports accept only 8-bit accesses (`req_size` = 0). A mismatched access raises `rsp_err`, returns 0 and changes no state.
- R6: An 8-bit command write of `ACPI_ON_CODE` (default 0xA0) sets `sci_enable` and `pwrbtn_arm`. One of `ACPI_OFF_CODE` (default 0xA1) clears both. Any other code changes neither.
- R7: A read of the command port raises `rsp_err` and returns 0.
- R8: An 8-bit write to the reset port stores the byte, and a read returns it in bits 7:0 with bits 15:8 as 0.
- R9: A reset-port write whose bit 2 is 1 while the stored bit 2 is 0 makes `sysrst_req` high for exactly the next cycle. Other reset-port writes do not.
- R10: Reset-port bit 1 (hard/soft select) has no effect on `sysrst_req`.
- R11: A valid access to any other address raises `rsp_err` and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data, same cycle |
| rsp_err | output | 1 | Access rejected, same cycle |
| sci_enable | output | 1 | ACPI mode active |
| pwrbtn_arm | output | 1 | Power-button events forwarded |
| pwroff_req | output | 1 | One-cycle soft power-off request |
| sysrst_req | output | 1 | One-cycle system reset request |

## Verification
Some properties are checked by assertions on every cycle:
- every power-off or reset pulse is traced back to a qualifying write in the cycle before;
- `sci_enable` is shown to move only after an accepted command write;
- rejected accesses are shown to leave the stored registers unchanged;
- the reserved control bits are shown to read as zero.

The bench scenarios are needed for the rest. They show that other sleep types, other command codes and a reset bit already set produce nothing. They also check the exact read-back values and that the hard/soft select leaves the reset pulse unchanged.

// File: rtl/acpi_pm_pkg.sv
package acpi_pm_pkg;

    localparam int REG_W      = 16;
    localparam int BYTE_W     = 8;
    localparam int SLPT_LSB   = 10;
    localparam int SLPT_W     = 3;
    localparam int SLPEN_BIT  = 13;
    localparam int RSTGO_BIT  = 2;
    localparam logic [SLPT_W-1:0] SOFT_OFF_TYPE = 3'd5;
    localparam logic [REG_W-1:0]  CTRL_KEEP_MASK = 16'h1FFC;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CTRL = 2'd1,
        TGT_CMD  = 2'd2,
        TGT_RSTP = 2'd3
    } target_e;

    typedef struct packed {
        logic ctrl_wr;
        logic ctrl_rd;
        logic cmd_wr;
        logic rstp_wr;
        logic rstp_rd;
        logic err;
    } access_t;

    function automatic logic [REG_W-1:0] ctrl_keep(input logic [REG_W-1:0] d);
        return d & CTRL_KEEP_MASK;
    endfunction

    function automatic logic is_soft_off(input logic [REG_W-1:0] d);
        return d[SLPEN_BIT] && (d[SLPT_LSB +: SLPT_W] == SOFT_OFF_TYPE);
    endfunction

endpackage

// File: rtl/pm_access_decode.sv
module pm_access_decode
    import acpi_pm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h04,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'hB2,
    parameter logic [ADDR_W-1:0] RSTP_ADDR = 8'hF9
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output access_t           acc
);
    target_e tgt;
    logic    size_ok;

    always_comb begin
        if (addr == CTRL_ADDR)      tgt = TGT_CTRL;
        else if (addr == CMD_ADDR)  tgt = TGT_CMD;
        else if (addr == RSTP_ADDR) tgt = TGT_RSTP;
        else                        tgt = TGT_NONE;
    end

    always_comb begin
        case (tgt)
            TGT_CTRL: size_ok = (size == SZ_HALF);
            TGT_CMD:  size_ok = (size == SZ_BYTE) && write;
            TGT_RSTP: size_ok = (size == SZ_BYTE);
            default:  size_ok = 1'b0;
        endcase
    end

    always_comb begin
        acc         = '0;
        acc.err     = valid && !size_ok;
        acc.ctrl_wr = valid && size_ok && write  && (tgt == TGT_CTRL);
        acc.ctrl_rd = valid && size_ok && !write && (tgt == TGT_CTRL);
        acc.cmd_wr  = valid && size_ok && write  && (tgt == TGT_CMD);
        acc.rstp_wr = valid && size_ok && write  && (tgt == TGT_RSTP);
        acc.rstp_rd = valid && size_ok && !write && (tgt == TGT_RSTP);
    end

    // R5: at most one register selected, never together with an error
    always_comb begin
        if (valid)
            assert ($countones({acc.ctrl_wr, acc.ctrl_rd, acc.cmd_wr,
                                acc.rstp_wr, acc.rstp_rd, acc.err}) == 1)
                else $error("a_r5_one_outcome");
    end

endmodule

// File: rtl/acpi_mode_unit.sv
module acpi_mode_unit
    import acpi_pm_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ON_CODE  = 8'hA0,
    parameter logic [BYTE_W-1:0] OFF_CODE = 8'hA1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [BYTE_W-1:0] cmd_code,
    output logic              sci_set,
    output logic              sci_clr,
    output logic              arm
);
    assign sci_set = cmd_wr && (cmd_code == ON_CODE);
    assign sci_clr = cmd_wr && (cmd_code == OFF_CODE);

    always_ff @(posedge clk) begin
        if (rst)          arm <= 1'b0;
        else if (sci_set) arm <= 1'b1;
        else if (sci_clr) arm <= 1'b0;
    end

    a_r6_arm_moves_on_cmd: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |=> $stable(arm));

endmodule

// File: rtl/pm1_ctrl_reg.sv
module pm1_ctrl_reg
    import acpi_pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             sci_set,
    input  logic             sci_clr,
    output logic [REG_W-1:0] rd_value,
    output logic             sci_en,
    output logic             pwroff_req
);
    logic [REG_W-1:0] kept_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kept_q     <= '0;
            pwroff_req <= 1'b0;
        end else begin
            pwroff_req <= wr && is_soft_off(wdata);
            if (wr) kept_q <= ctrl_keep(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          sci_en <= 1'b0;
        else if (sci_set) sci_en <= 1'b1;
        else if (sci_clr) sci_en <= 1'b0;
    end

    assign rd_value = {kept_q[REG_W-1:1], sci_en};

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        rd_value[15:13] == 3'b000 && rd_value[1] == 1'b0);
    a_r3_sci_untouched: assert property (@(posedge clk) disable iff (rst)
        !(sci_set || sci_clr) |=> $stable(sci_en));
    a_r4_pwroff_cause: assert property (@(posedge clk) disable iff (rst)
        pwroff_req |-> $past(wr) && $past(wdata[SLPEN_BIT]));

endmodule

// File: rtl/reset_port_reg.sv
module reset_port_reg
    import acpi_pm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] value,
    output logic              sysrst_req
);
    logic go_rise;

    assign go_rise = wr && wdata[RSTGO_BIT] && !value[RSTGO_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            value      <= '0;
            sysrst_req <= 1'b0;
        end else begin
            sysrst_req <= go_rise;
            if (wr) value <= wdata;
        end
    end

    a_r9_rise_only: assert property (@(posedge clk) disable iff (rst)
        sysrst_req |-> $past(wr) && !$past(value[RSTGO_BIT]) && value[RSTGO_BIT]);
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(value));

endmodule

// File: rtl/acpi_sleep_ctrl.sv
module acpi_sleep_ctrl
    import acpi_pm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h04,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'hB2,
    parameter logic [ADDR_W-1:0] RSTP_ADDR = 8'hF9,
    parameter logic [7:0] ACPI_ON_CODE  = 8'hA0,
    parameter logic [7:0] ACPI_OFF_CODE = 8'hA1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [15:0]       req_wdata,
    output logic [15:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              sci_enable,
    output logic              pwrbtn_arm,
    output logic              pwroff_req,
    output logic              sysrst_req
);
    access_t           acc;
    logic              sci_set, sci_clr;
    logic [REG_W-1:0]  ctrl_value;
    logic [BYTE_W-1:0] rstp_value;

    pm_access_decode #(
        .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
        .CMD_ADDR(CMD_ADDR), .RSTP_ADDR(RSTP_ADDR)
    ) u_dec (
        .valid(req_valid), .write(req_write), .addr(req_addr),
        .size(req_size), .acc(acc)
    );

    acpi_mode_unit #(.ON_CODE(ACPI_ON_CODE), .OFF_CODE(ACPI_OFF_CODE)) u_mode (
        .clk(clk), .rst(rst), .cmd_wr(acc.cmd_wr), .cmd_code(req_wdata[BYTE_W-1:0]),
        .sci_set(sci_set), .sci_clr(sci_clr), .arm(pwrbtn_arm)
    );

    pm1_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .wr(acc.ctrl_wr), .wdata(req_wdata),
        .sci_set(sci_set), .sci_clr(sci_clr), .rd_value(ctrl_value),
        .sci_en(sci_enable), .pwroff_req(pwroff_req)
    );

    reset_port_reg u_rstp (
        .clk(clk), .rst(rst), .wr(acc.rstp_wr), .wdata(req_wdata[BYTE_W-1:0]),
        .value(rstp_value), .sysrst_req(sysrst_req)
    );

    always_comb begin
        rsp_err = acc.err;
        if (acc.ctrl_rd)      rsp_rdata = ctrl_value;
        else if (acc.rstp_rd) rsp_rdata = {{(REG_W-BYTE_W){1'b0}}, rstp_value};
        else                  rsp_rdata = '0;
    end

    a_r5_err_keeps_ctrl: assert property (@(posedge clk) disable iff (rst)
        rsp_err |=> $stable(ctrl_value) && $stable(rstp_value) && $stable(sci_enable));
    a_r7_err_reads_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_rdata == '0);
    a_r6_arm_follows_sci: assert property (@(posedge clk) disable iff (rst)
        pwrbtn_arm == sci_enable);

endmodule

// File: tb/tb_acpi_sleep_ctrl.sv
module tb_acpi_sleep_ctrl;
    localparam logic [7:0] A_CTRL = 8'h04;
    localparam logic [7:0] A_CMD  = 8'hB2;
    localparam logic [7:0] A_RSTP = 8'hF9;
    localparam logic [7:0] A_NONE = 8'h40;

    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_write;
    logic [7:0]  req_addr;
    logic [1:0]  req_size;
    logic [15:0] req_wdata;
    logic [15:0] rsp_rdata;
    logic rsp_err, sci_enable, pwrbtn_arm, pwroff_req, sysrst_req;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // reference model state
    logic [15:0] m_ctrl;
    logic        m_sci;
    logic [7:0]  m_rstp;
    logic        m_off, m_rstq;

    always #5 clk = ~clk;

    acpi_sleep_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .sci_enable(sci_enable),
        .pwrbtn_arm(pwrbtn_arm), .pwroff_req(pwroff_req), .sysrst_req(sysrst_req)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctrl = '0; m_sci = 1'b0; m_rstp = '0; m_off = 1'b0; m_rstq = 1'b0;
    endtask

    // one bus cycle: drive after negedge, compare, then advance model over the edge
    task automatic op(input string tag, input logic v, input logic w,
                      input logic [7:0] a, input logic [1:0] s, input logic [15:0] d);
        logic ok, e_err;
        logic [15:0] e_rd;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_size = s; req_wdata = d;
        #1;
        ok = 1'b0;
        if (a == A_CTRL)      ok = (s == 2'd1);
        else if (a == A_CMD)  ok = (s == 2'd0) && w;
        else if (a == A_RSTP) ok = (s == 2'd0);
        e_err = v && !ok;
        e_rd  = 16'h0;
        if (v && ok && !w) begin
            if (a == A_CTRL) e_rd = m_ctrl | {15'h0, m_sci};
            else             e_rd = {8'h00, m_rstp};
        end
        cmp(tag, "rsp_err", int'(rsp_err), int'(e_err));
        cmp(tag, "rsp_rdata", int'(rsp_rdata), int'(e_rd));
        cmp(tag, "sci_enable", int'(sci_enable), int'(m_sci));
        cmp(tag, "pwrbtn_arm", int'(pwrbtn_arm), int'(m_sci));
        cmp(tag, "pwroff_req", int'(pwroff_req), int'(m_off));
        cmp(tag, "sysrst_req", int'(sysrst_req), int'(m_rstq));
        @(posedge clk);
        m_off = 1'b0; m_rstq = 1'b0;
        if (v && ok && w) begin
            if (a == A_CTRL) begin
                m_off  = d[13] && (d[12:10] == 3'd5);
                m_ctrl = d & 16'h1FFC;
            end else if (a == A_CMD) begin
                if (d[7:0] == 8'hA0)      m_sci = 1'b1;
                else if (d[7:0] == 8'hA1) m_sci = 1'b0;
            end else begin
                m_rstq = d[2] && !m_rstp[2];
                m_rstp = d[7:0];
            end
        end
    endtask

    task automatic idle(input string tag);
        op(tag, 1'b0, 1'b0, A_NONE, 2'd0, 16'h0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 0; req_write = 0; req_addr = '0; req_size = '0; req_wdata = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        op("R1", 1, 0, A_CTRL, 2'd1, 16'h0);
        op("R1", 1, 0, A_RSTP, 2'd0, 16'h0);
        // R2 / R3: all-ones write, SLP_EN with type 7 (R4 negative)
        op("R2", 1, 1, A_CTRL, 2'd1, 16'hFFFF);
        op("R4", 1, 0, A_CTRL, 2'd1, 16'h0);
        // R6 enable ACPI mode
        op("R6", 1, 1, A_CMD, 2'd0, 16'h00A0);
        op("R3", 1, 0, A_CTRL, 2'd1, 16'h0);
        op("R3", 1, 1, A_CTRL, 2'd1, 16'h0000);
        op("R3", 1, 0, A_CTRL, 2'd1, 16'h0);
        // R4 soft-off and neighbours
        op("R4", 1, 1, A_CTRL, 2'd1, 16'h3400);
        op("R4", 1, 1, A_CTRL, 2'd1, 16'h3400);
        op("R4", 1, 1, A_CTRL, 2'd1, 16'h2C00);
        op("R4", 1, 1, A_CTRL, 2'd1, 16'h1400);
        op("R4", 1, 0, A_CTRL, 2'd1, 16'h0);
        // R5 size mismatches
        op("R5", 1, 1, A_CTRL, 2'd0, 16'h3455);
        op("R5", 1, 1, A_CTRL, 2'd2, 16'h3400);
        op("R5", 1, 1, A_CMD,  2'd1, 16'h00A1);
        op("R5", 1, 1, A_RSTP, 2'd1, 16'h0004);
        op("R5", 1, 0, A_CTRL, 2'd1, 16'h0);
        op("R5", 1, 0, A_RSTP, 2'd0, 16'h0);
        // R6 other code, R7 read of command port, then disable
        op("R6", 1, 1, A_CMD, 2'd0, 16'h0055);
        op("R7", 1, 0, A_CMD, 2'd0, 16'h0);
        op("R6", 1, 1, A_CMD, 2'd0, 16'hFFA1);
        op("R6", 1, 1, A_CMD, 2'd0, 16'h00A1);
        idle("R6");
        // R8 / R9 / R10 reset port
        op("R8", 1, 1, A_RSTP, 2'd0, 16'hAB5A);
        op("R8", 1, 0, A_RSTP, 2'd0, 16'h0);
        op("R9", 1, 1, A_RSTP, 2'd0, 16'h0006);
        op("R9", 1, 1, A_RSTP, 2'd0, 16'h0004);
        op("R9", 1, 1, A_RSTP, 2'd0, 16'h0000);
        op("R10", 1, 1, A_RSTP, 2'd0, 16'h0002);
        op("R10", 1, 1, A_RSTP, 2'd0, 16'h0004);
        op("R10", 1, 1, A_RSTP, 2'd0, 16'h0000);
        op("R10", 1, 1, A_RSTP, 2'd0, 16'h0006);
        idle("R9");
        // R11 unmapped
        op("R11", 1, 0, A_NONE, 2'd1, 16'h0);
        op("R11", 1, 1, 8'h05, 2'd1, 16'h3400);
        idle("R11");
        // R1 again after a mid-run reset
        op("R6", 1, 1, A_CMD, 2'd0, 16'h00A0);
        @(negedge clk); rst = 1'b1; req_valid = 0;
        @(posedge clk); @(negedge clk); rst = 1'b0;
        model_reset();
        op("R1", 1, 0, A_CTRL, 2'd1, 16'h0);
        op("R1", 1, 0, A_RSTP, 2'd0, 16'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule